// File: doc/BRIEF.md
# Timer Time Base with Preloaded Prescaler and Reload

This block is the counting core of a general-purpose timer. It divides the
system clock through a programmable prescaler, runs a 16-bit counter up or
down between zero and a reload value, and raises an update event whenever the
counter wraps. Downstream compare channels take the live count from
`count_o` and the update strobe from `upd_evt`.

Software reaches the block through a small write port and a combinational
read port. Prescaler and reload writes land in holding registers first. The
running counter only adopts them at an update event. An update event can be
blocked entirely, limited in what it reports, or forced at once by a
software strobe. An optional one-shot mode stops the counter after its first
update.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the counter is 0, the control word is 0, the prescaler reads 0, the reload reads all ones, and the update flag and interrupt request are low.
- R2: Register addresses: 0 control, 1 interrupt enable (bit 0), 2 status (bit 0 = update flag), 3 event strobe (bit 0), 4 counter, 5 prescaler, 6 reload. The control bits are: run at bit 0, update block at bit 1, overflow-only reporting at bit 2, one-shot at bit 3, count down at bit 4, and reload buffering at bit 7. Each readable register returns what was last written, on the cycle after the write, and the event address reads 0.
- R3: While counting up with run set, the counter steps once every (prescaler + 1) clocks. When it steps from a value at or above the effective reload, it wraps to 0 and that step is an overflow.
- R4: While counting down, the counter steps down once per prescaler period. When it steps from 0, it loads the reload value and that step is an underflow.
- R5: With run clear, the counter and prescaler phase hold their values. Setting run again resumes counting from the held count.
- R6: A prescaler write is readable at once, but the division ratio in use changes only at an update event.
- R7: With reload buffering set, the counter uses the reload value captured at the last update event. With it clear, a reload write is used from the next cycle.
- R8: Writing 1 to event bit 0 causes an update event in that cycle. The event loads the pending prescaler and reload values, clears the prescaler phase, and sets the counter to 0 (up) or to the new reload value (down). While update block is set, the strobe changes nothing.
- R9: While update block is set, wraps still happen, but no update event occurs: the pending values are not transferred and the flag is not set.
- R10: While overflow-only reporting is set, only an overflow or underflow sets the flag. A software strobe still transfers the pending values and resets the counter.
- R11: In one-shot mode, run clears at the first update event unless software writes the control word in that same cycle.
- R12: The update flag stays set until software writes status with bit 0 = 0. A set in the same cycle as that write wins. The interrupt request equals the flag ANDed with enable bit 0.
- R13: A counter write loads the value on the next cycle and takes priority over counting. `upd_evt` is high during exactly the cycles in which an update event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | CW | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | CW | Read data for rd_addr, combinational |
| count_o | output | CW | Live counter value |
| upd_evt | output | 1 | Update event in this cycle |
| upd_flag | output | 1 | Sticky update flag |
| upd_irq | output | 1 | Update interrupt request |

## Verification
A fault in the prescaler phase or the counter shows on `count_o` within one
prescaler period, because every step and every wrap is compared on every
cycle. A wrong transfer of a pending prescaler or reload value shows later.
It appears at the next wrap, as a count that wraps at the wrong value or
steps at the wrong rate. A fault in the flag or the control word shows on
`upd_flag`, `upd_irq` or the read port by the cycle after the event that
should have changed it. Randomly mixed writes exercise buffered and
immediate reloads, both directions, blocked updates and one-shot mode
against a cycle model kept in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_IEN  = 3'd1;
    localparam logic [AW-1:0] A_STAT = 3'd2;
    localparam logic [AW-1:0] A_EVT  = 3'd3;
    localparam logic [AW-1:0] A_CNT  = 3'd4;
    localparam logic [AW-1:0] A_PSC  = 3'd5;
    localparam logic [AW-1:0] A_RLD  = 3'd6;

    localparam int CB_RUN  = 0;
    localparam int CB_UDIS = 1;
    localparam int CB_URS  = 2;
    localparam int CB_OPM  = 3;
    localparam int CB_DOWN = 4;
    localparam int CB_ARPE = 7;

    typedef struct packed {
        logic arpe;
        logic down;
        logic opm;
        logic urs;
        logic udis;
        logic run;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter logic [CW-1:0] RLD_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          uev,
    input  logic          flag_set,
    output tmr_ctrl_t     ctrl,
    output logic          ien,
    output logic          flag,
    output logic [CW-1:0] psc_pre,
    output logic [CW-1:0] psc_act,
    output logic [CW-1:0] arr_pre,
    output logic [CW-1:0] reload_eff
);
    typedef struct packed {
        tmr_ctrl_t     ctrl;
        logic          ien;
        logic          flag;
        logic [CW-1:0] psc_pre;
        logic [CW-1:0] psc_act;
        logic [CW-1:0] arr_pre;
        logic [CW-1:0] arr_sh;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    st_d.ctrl.run  = wr_data[CB_RUN];
                    st_d.ctrl.udis = wr_data[CB_UDIS];
                    st_d.ctrl.urs  = wr_data[CB_URS];
                    st_d.ctrl.opm  = wr_data[CB_OPM];
                    st_d.ctrl.down = wr_data[CB_DOWN];
                    st_d.ctrl.arpe = wr_data[CB_ARPE];
                end
                A_IEN:  st_d.ien = wr_data[0];
                A_STAT: if (!wr_data[0]) st_d.flag = 1'b0;
                A_PSC:  st_d.psc_pre = wr_data;
                A_RLD:  st_d.arr_pre = wr_data;
                default: ;
            endcase
        end
        if (uev) begin
            st_d.psc_act = st_q.psc_pre;
            st_d.arr_sh  = st_q.arr_pre;
            if (st_q.ctrl.opm && !ctrl_wr) st_d.ctrl.run = 1'b0;
        end
        if (flag_set) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.arr_pre <= RLD_RST;
            st_q.arr_sh  <= RLD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl       = st_q.ctrl;
    assign ien        = st_q.ien;
    assign flag       = st_q.flag;
    assign psc_pre    = st_q.psc_pre;
    assign psc_act    = st_q.psc_act;
    assign arr_pre    = st_q.arr_pre;
    assign reload_eff = st_q.ctrl.arpe ? st_q.arr_sh : st_q.arr_pre;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [CW-1:0] psc_act,
    output logic          tick
);
    typedef struct packed {
        logic [CW-1:0] phase;
    } psc_t;

    psc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.phase >= psc_act);
        if (clr) begin
            st_d.phase = '0;
        end else if (run) begin
            st_d.phase = tick ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          down,
    input  logic [CW-1:0] reload_eff,
    input  logic [CW-1:0] reload_new,
    input  logic          sw_reset,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] cnt,
    output logic          wrap_evt
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic at_end;

    always_comb begin
        st_d     = st_q;
        at_end   = down ? (st_q.cnt == '0) : (st_q.cnt >= reload_eff);
        wrap_evt = tick && at_end;
        if (ld) begin
            st_d.cnt = ld_val;
        end else if (sw_reset) begin
            st_d.cnt = down ? reload_new : '0;
        end else if (tick) begin
            if (at_end) st_d.cnt = down ? reload_new : '0;
            else        st_d.cnt = down ? st_q.cnt - 1'b1 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter logic [CW-1:0] RLD_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    output logic [CW-1:0] count_o,
    output logic          upd_evt,
    output logic          upd_flag,
    output logic          upd_irq
);
    tmr_ctrl_t     ctrl;
    logic          ien, flag, tick, ovf, sw_ug, uev, flag_set, cnt_ld;
    logic [CW-1:0] psc_pre, psc_act, arr_pre, reload_eff, reload_new, cnt;

    always_comb begin
        sw_ug      = wr_en && (wr_addr == A_EVT) && wr_data[0];
        cnt_ld     = wr_en && (wr_addr == A_CNT);
        uev        = (ovf || sw_ug) && !ctrl.udis;
        flag_set   = uev && (!ctrl.urs || ovf);
        reload_new = uev ? arr_pre : reload_eff;
    end

    tmr_regs #(.CW(CW), .RLD_RST(RLD_RST)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .uev       (uev),
        .flag_set  (flag_set),
        .ctrl      (ctrl),
        .ien       (ien),
        .flag      (flag),
        .psc_pre   (psc_pre),
        .psc_act   (psc_act),
        .arr_pre   (arr_pre),
        .reload_eff(reload_eff)
    );

    tmr_prescaler #(.CW(CW)) i_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl.run),
        .clr    (uev),
        .psc_act(psc_act),
        .tick   (tick)
    );

    tmr_counter #(.CW(CW)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .down      (ctrl.down),
        .reload_eff(reload_eff),
        .reload_new(reload_new),
        .sw_reset  (sw_ug && !ctrl.udis),
        .ld        (cnt_ld),
        .ld_val    (wr_data),
        .cnt       (cnt),
        .wrap_evt  (ovf)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[CB_RUN]  = ctrl.run;
                rd_data[CB_UDIS] = ctrl.udis;
                rd_data[CB_URS]  = ctrl.urs;
                rd_data[CB_OPM]  = ctrl.opm;
                rd_data[CB_DOWN] = ctrl.down;
                rd_data[CB_ARPE] = ctrl.arpe;
            end
            A_IEN:  rd_data[0] = ien;
            A_STAT: rd_data[0] = flag;
            A_CNT:  rd_data = cnt;
            A_PSC:  rd_data = psc_pre;
            A_RLD:  rd_data = arr_pre;
            default: rd_data = '0;
        endcase
    end

    assign count_o  = cnt;
    assign upd_evt  = uev;
    assign upd_flag = flag;
    assign upd_irq  = flag && ien;
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [CW-1:0] wr_data,
    input logic [CW-1:0] count_o,
    input logic          upd_evt,
    input logic          upd_flag,
    input logic          upd_irq,
    input logic          run,
    input logic          udis,
    input logic          opm,
    input logic          down,
    input logic          tick,
    input logic [CW-1:0] reload_eff
);
    logic sw_touch, ctrl_wr, stat_clr;
    assign sw_touch = wr_en && (wr_addr == A_CNT || wr_addr == A_EVT);
    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign stat_clr = wr_en && (wr_addr == A_STAT) && !wr_data[0];

    assert_irq_needs_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        upd_irq |-> upd_flag);

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !stat_clr) |=> upd_flag);

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sw_touch) |=> $stable(count_o));

    assert_no_flag_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (udis && !upd_flag) |=> !upd_flag);

    assert_blocked_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        udis |-> !upd_evt);

    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down && count_o < reload_eff && !sw_touch)
        |=> count_o == CW'($past(count_o) + 1'b1));

    assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down && count_o != '0 && !sw_touch)
        |=> count_o == CW'($past(count_o) - 1'b1));

    assert_one_shot_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (opm && upd_evt && !ctrl_wr) |=> !run);
endmodule

bind tmr_timebase tmr_timebase_chk #(.CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count_o   (count_o),
    .upd_evt   (upd_evt),
    .upd_flag  (upd_flag),
    .upd_irq   (upd_irq),
    .run       (ctrl.run),
    .udis      (ctrl.udis),
    .opm       (ctrl.opm),
    .down      (ctrl.down),
    .tick      (tick),
    .reload_eff(reload_eff)
);

// File: tb/test_tmr_timebase.sv
`timescale 1ns/1ps
module test_tmr_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data, count_o;
    logic        upd_evt, upd_flag, upd_irq;

    always #2 clk = ~clk;

    tmr_timebase #(.CW(16)) i_tmr_timebase (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .count_o(count_o), .upd_evt(upd_evt), .upd_flag(upd_flag),
        .upd_irq(upd_irq)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // bench model state, built from the requirements
    logic        m_run, m_udis, m_urs, m_opm, m_down, m_arpe, m_ien, m_flag;
    logic [15:0] m_psc_pre, m_psc_act, m_arr_pre, m_arr_sh, m_pc, m_cnt;

    function automatic logic [15:0] m_reff();
        return m_arpe ? m_arr_sh : m_arr_pre;
    endfunction
    function automatic logic m_tick();
        return m_run && (m_pc >= m_psc_act);
    endfunction
    function automatic logic m_wrap();
        return m_down ? (m_cnt == 16'd0) : (m_cnt >= m_reff());
    endfunction
    function automatic logic m_sw();
        return wr_en && wr_addr == 3'd3 && wr_data[0];
    endfunction
    function automatic logic m_uev();
        return ((m_tick() && m_wrap()) || m_sw()) && !m_udis;
    endfunction
    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {8'd0, m_arpe, 2'd0, m_down, m_opm, m_urs, m_udis, m_run};
            3'd1: return {15'd0, m_ien};
            3'd2: return {15'd0, m_flag};
            3'd4: return m_cnt;
            3'd5: return m_psc_pre;
            3'd6: return m_arr_pre;
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_run, m_udis, m_urs, m_opm, m_down, m_arpe, m_ien, m_flag} = '0;
            m_psc_pre = 0; m_psc_act = 0; m_pc = 0; m_cnt = 0;
            m_arr_pre = 16'hFFFF; m_arr_sh = 16'hFFFF;
        end else begin
            logic        tk, ov, sw, ue, fs;
            logic [15:0] rn, n_cnt;
            tk = m_tick(); ov = tk && m_wrap(); sw = m_sw(); ue = m_uev();
            fs = ue && (!m_urs || ov);
            rn = ue ? m_arr_pre : m_reff();
            n_cnt = m_cnt;
            if (wr_en && wr_addr == 3'd4) n_cnt = wr_data;
            else if (sw && !m_udis) n_cnt = m_down ? rn : 16'd0;
            else if (tk) n_cnt = m_wrap() ? (m_down ? rn : 16'd0)
                                          : (m_down ? m_cnt - 16'd1 : m_cnt + 16'd1);
            if (ue) m_pc = 0;
            else if (m_run) m_pc = tk ? 16'd0 : m_pc + 16'd1;
            m_cnt = n_cnt;
            if (ue) begin
                m_psc_act = m_psc_pre; m_arr_sh = m_arr_pre;
            end
            if (ue && m_opm && !(wr_en && wr_addr == 3'd0)) m_run = 1'b0;
            if (wr_en) case (wr_addr)
                3'd0: {m_arpe, m_down, m_opm, m_urs, m_udis, m_run} =
                      {wr_data[7], wr_data[4], wr_data[3], wr_data[2], wr_data[1], wr_data[0]};
                3'd1: m_ien = wr_data[0];
                3'd2: if (!wr_data[0]) m_flag = 1'b0;
                3'd5: m_psc_pre = wr_data;
                3'd6: m_arr_pre = wr_data;
                default: ;
            endcase
            if (fs) m_flag = 1'b1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic we, input logic [2:0] a,
                       input logic [15:0] d, input logic [2:0] ra);
        @(negedge clk);
        chk(cur_req, "count", count_o, m_cnt);
        chk(cur_req, "flag", {15'd0, upd_flag}, {15'd0, m_flag});
        chk(cur_req, "irq", {15'd0, upd_irq}, {15'd0, m_flag && m_ien});
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        #1;
        chk(cur_req, "rd_data", rd_data, m_read(ra));
        chk(cur_req, "upd_evt", {15'd0, upd_evt}, {15'd0, m_uev()});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'd0, 3'(i % 7));
    endtask

    task automatic peek(input logic [2:0] ra, input logic [15:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; rd_addr = ra;
        #1;
        chk(req, "hand", rd_data, exp);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL all: watchdog expired, actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        peek(3'd0, 16'h0000, "R1");
        peek(3'd5, 16'h0000, "R1");
        peek(3'd6, 16'hFFFF, "R1");
        peek(3'd4, 16'h0000, "R1");
        peek(3'd2, 16'h0000, "R1");
        idle(2);

        // R2 control readback and prescaler visibility (R6)
        cur_req = "R2";
        cyc(1'b1, 3'd0, 16'h009E, 3'd0);
        peek(3'd0, 16'h009E, "R2");
        cyc(1'b1, 3'd0, 16'h0000, 3'd0);
        cyc(1'b1, 3'd5, 16'd2, 3'd5);
        peek(3'd5, 16'd2, "R6");
        peek(3'd3, 16'd0, "R2");

        // R3/R7 up counting with immediate reload, then R6 at overflow
        cur_req = "R7";
        cyc(1'b1, 3'd6, 16'd5, 3'd6);
        cur_req = "R3";
        cyc(1'b1, 3'd0, 16'h0001, 3'd4);
        idle(30);
        // R12 flag clear, irq enable
        cur_req = "R12";
        cyc(1'b1, 3'd1, 16'd1, 3'd2);
        idle(3);
        cyc(1'b1, 3'd2, 16'd0, 3'd2);
        idle(4);

        // R5 freeze and resume
        cur_req = "R5";
        cyc(1'b1, 3'd0, 16'h0000, 3'd4);
        idle(6);
        cyc(1'b1, 3'd0, 16'h0001, 3'd4);
        idle(6);

        // R7 buffered reload
        cur_req = "R7";
        cyc(1'b1, 3'd0, 16'h0081, 3'd0);
        cyc(1'b1, 3'd6, 16'd2, 3'd6);
        idle(25);

        // R4 down counting
        cur_req = "R4";
        cyc(1'b1, 3'd0, 16'h0011, 3'd0);
        idle(25);

        // R8 strobe blocked by update block
        cur_req = "R8";
        cyc(1'b1, 3'd2, 16'd0, 3'd2);
        cyc(1'b1, 3'd0, 16'h0002, 3'd0);
        cyc(1'b1, 3'd4, 16'd7, 3'd4);
        cyc(1'b1, 3'd3, 16'd1, 3'd4);
        peek(3'd4, 16'd7, "R8");
        peek(3'd2, 16'd0, "R8");
        // R8 strobe applies pending values
        cyc(1'b1, 3'd0, 16'h0001, 3'd0);
        cyc(1'b1, 3'd5, 16'd1, 3'd5);
        cyc(1'b1, 3'd3, 16'd1, 3'd4);
        idle(12);

        // R9 update block while running
        cur_req = "R9";
        cyc(1'b1, 3'd2, 16'd0, 3'd2);
        cyc(1'b1, 3'd0, 16'h0003, 3'd0);
        cyc(1'b1, 3'd5, 16'd0, 3'd5);
        idle(20);

        // R10 overflow-only reporting
        cur_req = "R10";
        cyc(1'b1, 3'd0, 16'h0004, 3'd0);
        cyc(1'b1, 3'd3, 16'd1, 3'd2);
        idle(3);
        cyc(1'b1, 3'd0, 16'h0005, 3'd0);
        idle(15);

        // R11 one-shot
        cur_req = "R11";
        cyc(1'b1, 3'd4, 16'd0, 3'd4);
        cyc(1'b1, 3'd0, 16'h0009, 3'd0);
        idle(20);
        peek(3'd0, 16'h0008, "R11");

        // R13 direct count load while running
        cur_req = "R13";
        cyc(1'b1, 3'd0, 16'h0001, 3'd0);
        cyc(1'b1, 3'd4, 16'd1, 3'd4);
        idle(5);

        // mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [2:0]  a;
            logic [15:0] d;
            logic        we;
            we = ($urandom_range(0, 3) == 0);
            a  = 3'($urandom_range(0, 6));
            d  = 16'($urandom);
            case (a)
                3'd0: begin
                    d[0] = ($urandom_range(0, 4) != 0);
                    d[1] = ($urandom_range(0, 5) == 0);
                    cur_req = "R11";
                end
                3'd2: cur_req = "R12";
                3'd3: cur_req = "R8";
                3'd4: begin d = 16'($urandom_range(0, 15)); cur_req = "R13"; end
                3'd5: begin d = 16'($urandom_range(0, 3)); cur_req = "R6"; end
                3'd6: begin d = 16'($urandom_range(0, 12)); cur_req = "R7"; end
                default: cur_req = "R3";
            endcase
            cyc(we, a, d, 3'($urandom_range(0, 7)));
        end
        idle(2);

        done = 1;
        summary();
        $finish;
    end
endmodule